// File: doc/BRIEF.md
# Systolic Two-Dimensional Recursive Image Filter

This block applies a second-order (by default) two-dimensional recursive filter to a stream of pixels that arrives in raster order, one pixel per clock, M pixels to a row. Each accepted pixel yields its filtered value in the same cycle, with no pipeline latency. The output is also fed back into the recursion. The filter computes

y(n,m) = sum over i,j in 0..N of a(i,j)·x(n-i,m-j) + sum over i,j in 0..N, (i,j) not (0,0), of b(i,j)·y(n-i,m-j)

Here n is the row and m is the column. Pixels outside the image, above its first row or left of its first column, count as zero.

The array has N+1 parallel sub-blocks, one per column offset j. Each sub-block is a column of processing elements: a row-0 element and ceil(N/2) pair elements. Each pair element serves two consecutive row orders. Pair elements hand their partial sums down the column through line buffers that are two rows long, and the first one hands on through a buffer that is one row long. The sub-block sums are then merged through a chain of single registers that supplies the column delays. Partial sums keep full precision. Only the final sum is rounded and saturated to the pixel width. The coefficients are static inputs, and a frame is started by a reset.

Top module: `sysfilt2d_iir`

## Requirements
- R1: For every cycle with in_valid high, out_data carries the filtered value of the pixel on in_data in that same cycle, and out_valid equals in_valid.
- R2: The output follows the recursion above. Pixels and outputs are 16-bit two's complement. Coefficients are 16-bit two's complement with 14 fraction bits. Coefficient (i,j) sits in bits [(i·(N+1)+j)·16 +: 16] of coef_a and of coef_b.
- R3: The exact sum, scaled by 2^14, is rounded by adding 2^13 and shifting right arithmetically by 14. It is then clamped to the range -32768..32767.
- R4: The b(0,0) field of coef_b has no effect on any output.
- R5: After reset, every row-delay and column-delay store is zero. Rows above the first row therefore count as zero, and with in_data at zero the output is zero.
- R6: Terms that reach left of column 0 count as zero and never pick up pixels from the end of the previous row.
- R7: While in_valid is low, in_data is ignored, no stored state changes, and out_valid is low.
- R8: The column position advances once per accepted pixel and returns to column 0 after column M-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset, clears all delay storage |
| in_valid | input | 1 | Pixel on in_data is accepted this cycle |
| in_data | input | 16 | Input pixel, signed |
| coef_a | input | (N+1)²·16 | Numerator coefficients, signed Q2.14 |
| coef_b | input | (N+1)²·16 | Feedback coefficients, signed Q2.14 |
| out_valid | output | 1 | Output valid, same cycle as input |
| out_data | output | 16 | Filtered pixel, signed, rounded and saturated |

## Verification
A single nonzero pixel at the top-left corner traces the impulse response. It shows whether every row and column delay lands at the right offset and whether feedback wraps across row ends. Dense random images with random stable coefficients test the full recursion, rounding included. One of these frames sets a large b(0,0), which would change every pixel if it were used. A second one has idle cycles with junk data scattered through the stream, and it shows whether a stall corrupts state. Large pixels with large gains drive the output into clamping, and the clamped values then feed the recursion. Each frame starts with a reset right after a busy frame, so any stale row content would show in row 0.

// File: rtl/sf2_pkg.sv
`timescale 1ns/1ps
package sf2_pkg;

    localparam int DATA_W = 16;
    localparam int COEF_W = 16;
    localparam int FRAC_W = 14;
    localparam int ACC_W  = 40;

    typedef logic signed [DATA_W-1:0] pix_t;
    typedef logic signed [COEF_W-1:0] coef_t;
    typedef logic signed [ACC_W-1:0]  acc_t;

    // coefficients seen by one pair element: two row orders, both polarities
    typedef struct packed {
        coef_t fwd_lo;
        coef_t fwd_hi;
        coef_t fbk_lo;
        coef_t fbk_hi;
    } pair_coef_t;

    localparam acc_t PIX_MAX  = acc_t'((1 <<< (DATA_W-1)) - 1);
    localparam acc_t PIX_MIN  = -PIX_MAX - acc_t'(1);
    localparam acc_t HALF_LSB = acc_t'(1 <<< (FRAC_W-1));

    function automatic acc_t mul(pix_t p, coef_t c);
        acc_t pe;
        acc_t ce;
        pe = acc_t'(p);
        ce = acc_t'(c);
        return pe * ce;
    endfunction

    function automatic pix_t quantise(acc_t v);
        acc_t r;
        r = (v + HALF_LSB) >>> FRAC_W;
        if (r > PIX_MAX) r = PIX_MAX;
        else if (r < PIX_MIN) r = PIX_MIN;
        return pix_t'(r);
    endfunction

endpackage

// File: rtl/sf2_line_delay.sv
`timescale 1ns/1ps
module sf2_line_delay #(
    parameter int W = 16,
    parameter int L = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stage_q [L];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < L; s++) stage_q[s] <= '0;
        end else if (en) begin
            stage_q[0] <= din;
            for (int s = 1; s < L; s++) stage_q[s] <= stage_q[s-1];
        end
    end

    assign dout = stage_q[L-1];
endmodule

// File: rtl/sf2_pair_pe.sv
`timescale 1ns/1ps
module sf2_pair_pe
    import sf2_pkg::*;
(
    input  pix_t       x_now,
    input  pix_t       x_row,
    input  pix_t       y_now,
    input  pix_t       y_row,
    input  pair_coef_t cf,
    input  acc_t       t_in,
    output acc_t       t_out
);
    acc_t fwd_sum;
    acc_t fbk_sum;

    always_comb begin
        fwd_sum = mul(x_now, cf.fwd_lo) + mul(x_row, cf.fwd_hi);
        fbk_sum = mul(y_now, cf.fbk_lo) + mul(y_row, cf.fbk_hi);
        t_out   = fwd_sum + fbk_sum + t_in;
    end
endmodule

// File: rtl/sf2_subblock.sv
`timescale 1ns/1ps
module sf2_subblock
    import sf2_pkg::*;
#(
    parameter int N = 2,
    parameter int M = 8,
    parameter int J = 0
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          en,
    input  pix_t                          x_now,
    input  pix_t                          x_row,
    input  pix_t                          y_now,
    input  pix_t                          y_row,
    input  logic [(N+1)*(N+1)*COEF_W-1:0] coef_a,
    input  logic [(N+1)*(N+1)*COEF_W-1:0] coef_b,
    output acc_t                          s_out
);
    localparam int NC = N + 1;
    localparam int K  = (N + 1) / 2;

    pair_coef_t pc    [1:K];
    acc_t       t_out [1:K];
    acc_t       t_in  [1:K];
    acc_t       t_row0;
    coef_t      a_zero;
    coef_t      b_zero;

    assign a_zero = coef_a[(0*NC+J)*COEF_W +: COEF_W];
    assign b_zero = coef_b[(0*NC+J)*COEF_W +: COEF_W];

    for (genvar k = 1; k <= K; k++) begin : g_pair
        assign pc[k].fwd_lo = coef_a[((2*k-1)*NC+J)*COEF_W +: COEF_W];
        assign pc[k].fbk_lo = coef_b[((2*k-1)*NC+J)*COEF_W +: COEF_W];
        if (2*k <= N) begin : g_hi
            assign pc[k].fwd_hi = coef_a[((2*k)*NC+J)*COEF_W +: COEF_W];
            assign pc[k].fbk_hi = coef_b[((2*k)*NC+J)*COEF_W +: COEF_W];
        end else begin : g_nohi
            assign pc[k].fwd_hi = '0;
            assign pc[k].fbk_hi = '0;
        end

        // deeper element output reaches this one two rows later
        if (k < K) begin : g_link
            sf2_line_delay #(.W(ACC_W), .L(2*M)) u_dly (
                .clk (clk),
                .rst (rst),
                .en  (en),
                .din (t_out[k+1]),
                .dout(t_in[k])
            );
        end else begin : g_tail
            assign t_in[k] = '0;
        end

        sf2_pair_pe u_pe (
            .x_now(x_now),
            .x_row(x_row),
            .y_now(y_now),
            .y_row(y_row),
            .cf   (pc[k]),
            .t_in (t_in[k]),
            .t_out(t_out[k])
        );
    end

    // first pair element reaches the row-0 element one row later
    sf2_line_delay #(.W(ACC_W), .L(M)) u_dly_row0 (
        .clk (clk),
        .rst (rst),
        .en  (en),
        .din (t_out[1]),
        .dout(t_row0)
    );

    if (J == 0) begin : g_row0_nofb
        // b(0,0) is outside the recursion
        assign s_out = mul(x_now, a_zero) + t_row0;
    end else begin : g_row0_fb
        assign s_out = mul(x_now, a_zero) + mul(y_now, b_zero) + t_row0;
    end
endmodule

// File: rtl/sysfilt2d_iir.sv
`timescale 1ns/1ps
module sysfilt2d_iir
    import sf2_pkg::*;
#(
    parameter int N = 2,
    parameter int M = 16
) (
    input  logic                                   clk,
    input  logic                                   rst,
    input  logic                                   in_valid,
    input  logic signed [DATA_W-1:0]               in_data,
    input  logic        [(N+1)*(N+1)*COEF_W-1:0]   coef_a,
    input  logic        [(N+1)*(N+1)*COEF_W-1:0]   coef_b,
    output logic                                   out_valid,
    output logic signed [DATA_W-1:0]               out_data
);
    localparam int CNT_W = (M > 2) ? $clog2(M) : 1;
    localparam logic [CNT_W-1:0] COL_LAST = CNT_W'(M - 1);

    pix_t             x_row;
    pix_t             y_now;
    pix_t             y_row;
    acc_t             s_vec   [0:N];
    acc_t             chain_q [1:N];
    acc_t             carry   [1:N];
    logic [CNT_W-1:0] col_q;

    // column position within the raster row
    always_ff @(posedge clk) begin
        if (rst) col_q <= '0;
        else if (in_valid) col_q <= (col_q == COL_LAST) ? '0 : col_q + 1'b1;
    end

    // one-row delays of input and quantised output, shared by all sub-blocks
    sf2_line_delay #(.W(DATA_W), .L(M)) u_xrow (
        .clk(clk), .rst(rst), .en(in_valid), .din(in_data), .dout(x_row)
    );
    sf2_line_delay #(.W(DATA_W), .L(M)) u_yrow (
        .clk(clk), .rst(rst), .en(in_valid), .din(y_now), .dout(y_row)
    );

    for (genvar j = 0; j <= N; j++) begin : g_sub
        sf2_subblock #(.N(N), .M(M), .J(j)) u_sub (
            .clk   (clk),
            .rst   (rst),
            .en    (in_valid),
            .x_now (in_data),
            .x_row (x_row),
            .y_now (y_now),
            .y_row (y_row),
            .coef_a(coef_a),
            .coef_b(coef_b),
            .s_out (s_vec[j])
        );
    end

    // column-delay chain; a term that would land past the row end is dropped
    for (genvar j = 1; j <= N; j++) begin : g_col
        if (j < N) begin : g_mid
            assign carry[j] = chain_q[j+1];
        end else begin : g_end
            assign carry[j] = '0;
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                chain_q[j] <= '0;
            end else if (in_valid) begin
                if (int'(col_q) >= M - j) chain_q[j] <= carry[j];
                else chain_q[j] <= s_vec[j] + carry[j];
            end
        end
    end

    assign y_now     = quantise(s_vec[0] + chain_q[1]);
    assign out_data  = y_now;
    assign out_valid = in_valid;
endmodule

// File: rtl/sf2_checker.sv
`timescale 1ns/1ps
module sf2_checker
    import sf2_pkg::*;
#(
    parameter int N     = 2,
    parameter int M     = 16,
    parameter int CNT_W = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic [CNT_W-1:0] col,
    input acc_t             c_first,
    input acc_t             c_last
);
    assert_col_range_R8: assert property (@(posedge clk) disable iff (rst)
        int'(col) < M);

    assert_col_wrap_R8: assert property (@(posedge clk) disable iff (rst)
        (in_valid && int'(col) == M - 1) |=> (col == '0));

    assert_col_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(col));

    assert_chain_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(c_first));

    assert_edge_drop_R6: assert property (@(posedge clk) disable iff (rst)
        (in_valid && int'(col) >= M - N) |=> (c_last == '0));
endmodule

bind sysfilt2d_iir sf2_checker #(.N(N), .M(M), .CNT_W(CNT_W)) u_sf2_chk (
    .clk     (clk),
    .rst     (rst),
    .in_valid(in_valid),
    .col     (col_q),
    .c_first (chain_q[1]),
    .c_last  (chain_q[N])
);

// File: tb/tb_sysfilt2d_iir.sv
`timescale 1ns/1ps
module tb_sysfilt2d_iir;
    localparam int N    = 2;
    localparam int M    = 8;
    localparam int ROWS = 6;
    localparam int NC   = N + 1;
    localparam int CVW  = NC * NC * 16;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               in_valid = 1'b0;
    logic signed [15:0] in_data = '0;
    logic [CVW-1:0]     coef_a = '0;
    logic [CVW-1:0]     coef_b = '0;
    logic               out_valid;
    logic signed [15:0] out_data;

    int checks = 0;
    int fails  = 0;
    int ca [0:N][0:N];
    int cb [0:N][0:N];
    int xh [0:ROWS-1][0:M-1];
    int yh [0:ROWS-1][0:M-1];

    always #2.5 clk = ~clk;

    sysfilt2d_iir #(.N(N), .M(M)) dut (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .in_data  (in_data),
        .coef_a   (coef_a),
        .coef_b   (coef_b),
        .out_valid(out_valid),
        .out_data (out_data)
    );

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int quant(longint v);
        longint r;
        r = (v + 64'sd8192) >>> 14;
        if (r > 32767) r = 32767;
        if (r < -32768) r = -32768;
        return int'(r);
    endfunction

    function automatic int model(int n, int m);
        longint acc = 0;
        for (int i = 0; i <= N; i++) begin
            for (int j = 0; j <= N; j++) begin
                if (n - i >= 0 && m - j >= 0) begin
                    acc += longint'(ca[i][j]) * longint'(xh[n-i][m-j]);
                    if (!(i == 0 && j == 0))
                        acc += longint'(cb[i][j]) * longint'(yh[n-i][m-j]);
                end
            end
        end
        return quant(acc);
    endfunction

    task automatic load_coefs();
        for (int i = 0; i <= N; i++)
            for (int j = 0; j <= N; j++) begin
                coef_a[(i*NC+j)*16 +: 16] = 16'(ca[i][j]);
                coef_b[(i*NC+j)*16 +: 16] = 16'(cb[i][j]);
            end
    endtask

    task automatic random_coefs(int amax, int bmax);
        for (int i = 0; i <= N; i++)
            for (int j = 0; j <= N; j++) begin
                ca[i][j] = int'($urandom_range(0, 2*amax)) - amax;
                cb[i][j] = int'($urandom_range(0, 2*bmax)) - bmax;
            end
        cb[0][0] = 0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        in_valid = 1'b0;
        in_data = '0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        #1;
        // R5: all delay stores cleared, zero input gives zero output
        check("R5", int'(out_data), 0);
        check("R7", int'(out_valid), 0);
    endtask

    // mode: 0 plain, 1 with stalls
    task automatic run_frame(string tag, int stall_mode);
        do_reset();
        for (int n = 0; n < ROWS; n++) begin
            for (int m = 0; m < M; m++) begin
                int exp;
                string t;
                if (stall_mode == 1 && $urandom_range(0, 2) == 0) begin
                    for (int s = 0; s < int'($urandom_range(1, 2)); s++) begin
                        @(negedge clk);
                        in_valid = 1'b0;
                        in_data  = 16'($urandom);
                        #1;
                        check("R7", int'(out_valid), 0);
                    end
                end
                @(negedge clk);
                in_valid = 1'b1;
                in_data  = 16'(xh[n][m]);
                exp = model(n, m);
                yh[n][m] = exp;
                #1;
                if (n == 0) t = "R5";
                else if (m == 0) t = "R8";
                else if (m < N) t = "R6";
                else t = tag;
                check("R1", int'(out_valid), 1);
                check(t, int'(out_data), exp);
            end
        end
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic random_image(int amp);
        for (int n = 0; n < ROWS; n++)
            for (int m = 0; m < M; m++)
                xh[n][m] = int'($urandom_range(0, 2*amp)) - amp;
    endtask

    initial begin
        #(200000 * 5);
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        // R2: impulse at the top-left corner
        random_coefs(8000, 1200);
        load_coefs();
        for (int n = 0; n < ROWS; n++)
            for (int m = 0; m < M; m++) xh[n][m] = 0;
        xh[0][0] = 12000;
        run_frame("R2", 0);

        // R2: dense random image
        random_coefs(8000, 1200);
        load_coefs();
        random_image(20000);
        run_frame("R2", 0);

        // R7: random image with idle cycles carrying junk
        random_coefs(8000, 1200);
        load_coefs();
        random_image(20000);
        run_frame("R7", 1);

        // R4: a large b(0,0) must not matter (model ignores it)
        random_coefs(8000, 1200);
        cb[0][0] = 12000;
        load_coefs();
        random_image(20000);
        cb[0][0] = 0;
        run_frame("R4", 0);

        // R3: large pixels and gains, output clamps
        random_coefs(30000, 4000);
        load_coefs();
        for (int n = 0; n < ROWS; n++)
            for (int m = 0; m < M; m++)
                xh[n][m] = ($urandom_range(0, 1) == 1) ? 30000 : -30000;
        run_frame("R3", 0);

        // R3: small pixels so the rounding step decides most outputs
        random_coefs(8000, 1200);
        load_coefs();
        random_image(6);
        run_frame("R3", 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule